// File: doc/BRIEF.md
# Software-Loaded Translation Buffer with Per-Entry Page Size

This block is a fully associative address translation buffer whose entries are filled and removed only by software. Software talks to it through four registers behind a two-bit select: an entry pointer, a low entry word (physical page, permissions, attribute bits), a high entry word (virtual tag, size code, valid and flag bits), and a process-identifier register. Software picks an entry through the pointer, then reads or writes that entry's two words. When the high word is written, the entry is tagged with the current process identifier. Reading the high word with the read strobe returns that tag to the identifier register.

A purely combinational lookup port translates a virtual address for a given process identifier and access kind. Each entry has its own three-bit size code, which sets how many address bits take part in the compare and which bits pass straight from the virtual to the physical address. Page sizes run from 1 KiB to 16 MiB in powers of four. The port reports a hit, a miss, the physical address and a permission fault. Register writes land on the clock edge, so the lookup port reflects them from the next cycle on.

Top module: `swtlb_unit`

## Requirements
- R1: The buffer holds 64 entries. Writing the pointer register (select 0) with a value V selects entry V[5:0] and marks the pointer invalid when V > 63. The pointer reads back as {invalid, V[5:0]} zero-extended. While the pointer is invalid, word writes are ignored and word reads return zero.
- R2: High word (select 2) layout: virtual tag in bits 31:10, size code in 9:7, valid in 6, endian flag in 5, user flag in 4. Bits 31:4 are stored, and bits 3:0 always read as zero.
- R3: Low word (select 1) layout: physical page in bits 31:10, execute permission in 9, write permission in 8, zone field in 7:4, and write-through, cache-inhibit, coherent and guarded in 3, 2, 1 and 0. All 32 bits are stored and read back. The zone and attribute bits have no effect on lookup.
- R4: A write to the high word records the identifier register (select 3, bits 7:0) as the entry's tag. A read strobe on the high word with a valid pointer loads the entry's tag into the identifier register on that edge.
- R5: After reset, every entry is zero, the pointer is 0 and valid, and the identifier register is 0. Every lookup misses.
- R6: An entry matches a lookup when three conditions hold: its valid bit is set; its tag equals the lookup identifier, or its tag is 0 (global); and the virtual address agrees with the virtual tag in bits 31 down to 10+2n, where n is the entry's size code.
- R7: On a hit, the physical address takes bits 31 down to 10+2n from the entry's low word and the bits below from the virtual address.
- R8: Access kind encoding: 0 read, 1 write, 2 fetch, 3 treated as read. A fault is raised on a hit for a write to an entry without write permission, or a fetch from an entry without execute permission. Reads never fault. The miss output is the inverse of hit.
- R9: When several entries match, the lowest-numbered one supplies the translation and the permissions.
- R10: Writing zero to an entry's identifier tag, high word and low word removes it, and lookups no longer match it.
- R11: A register write takes effect at the clock edge. The lookup port shows the new contents in the cycle right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_sel | input | 2 | Register select: 0 pointer, 1 low word, 2 high word, 3 identifier |
| csr_we | input | 1 | Write strobe for the selected register |
| csr_re | input | 1 | Read strobe (high word copies the tag into the identifier register) |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Combinational read data of the selected register |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_pid | input | 8 | Lookup process identifier |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| lk_hit | output | 1 | An entry matched |
| lk_miss | output | 1 | No entry matched |
| lk_fault | output | 1 | Permission violation on a hit |
| lk_paddr | output | 32 | Translated physical address |

## Verification
The assertions check several properties on every cycle:
- a fault never appears without a hit, and reads never fault;
- the 10 lowest address bits always pass through on a hit;
- a high-word write tags the entry with the identifier of the previous cycle;
- writes through an invalid pointer leave storage untouched;
- flag bits 3:0 of the high word read as zero.

Only the bench scenarios can show the rest:
- the size-dependent compare width at 1 KiB, 4 KiB and 16 MiB;
- global versus private tags;
- lowest-index priority when entries overlap;
- permission faults per access kind;
- the tag round trip through the identifier register;
- removal of entries by zero writes.

// File: rtl/swtlb_pkg.sv
package swtlb_pkg;
    typedef enum logic [1:0] {
        SEL_PTR = 2'd0,
        SEL_LO  = 2'd1,
        SEL_HI  = 2'd2,
        SEL_PID = 2'd3
    } csr_sel_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_ALT   = 2'd3
    } acc_kind_e;

    localparam int unsigned HI_VALID_BIT = 6;
    localparam int unsigned HI_SIZE_LSB  = 7;
    localparam int unsigned LO_WR_BIT    = 8;
    localparam int unsigned LO_EX_BIT    = 9;
    localparam logic [31:0] MIN_PAGE_KEEP = 32'hFFFF_FC00;

    // Offset mask for size code n: page of 2^(10+2n) bytes
    function automatic logic [31:0] page_off_mask(input logic [2:0] code);
        logic [4:0] sh;
        sh = 5'd10 + {1'b0, code, 1'b0};
        return (32'd1 << sh) - 32'd1;
    endfunction
endpackage

// File: rtl/swtlb_regs.sv
module swtlb_regs
    import swtlb_pkg::*;
#(
    parameter int unsigned N     = 64,
    parameter int unsigned PID_W = 8,
    localparam int unsigned IDX_W = $clog2(N)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  csr_sel,
    input  logic                        csr_we,
    input  logic                        csr_re,
    input  logic [31:0]                 csr_wdata,
    output logic [31:0]                 csr_rdata,
    output logic [N-1:0][31:0]          hi_words,
    output logic [N-1:0][31:0]          lo_words,
    output logic [N-1:0][PID_W-1:0]     tags
);
    typedef struct packed {
        logic [IDX_W-1:0]          idx;
        logic                      idx_bad;
        logic [PID_W-1:0]          pid;
        logic [N-1:0][31:0]        hi;
        logic [N-1:0][31:0]        lo;
        logic [N-1:0][PID_W-1:0]   tid;
    } state_t;

    state_t st_d, st_q;
    csr_sel_e sel;
    assign sel = csr_sel_e'(csr_sel);

    always_comb begin
        st_d = st_q;
        if (csr_we) begin
            case (sel)
                SEL_PTR: begin
                    st_d.idx_bad = (csr_wdata >= 32'(N));
                    st_d.idx     = csr_wdata[IDX_W-1:0];
                end
                SEL_LO: if (!st_q.idx_bad) st_d.lo[st_q.idx] = csr_wdata;
                SEL_HI: if (!st_q.idx_bad) begin
                    st_d.hi[st_q.idx]  = {csr_wdata[31:4], 4'b0000};
                    st_d.tid[st_q.idx] = st_q.pid;
                end
                SEL_PID: st_d.pid = csr_wdata[PID_W-1:0];
                default: ;
            endcase
        end else if (csr_re && sel == SEL_HI && !st_q.idx_bad) begin
            st_d.pid = st_q.tid[st_q.idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        csr_rdata = '0;
        case (sel)
            SEL_PTR: csr_rdata = 32'({st_q.idx_bad, st_q.idx});
            SEL_LO:  if (!st_q.idx_bad) csr_rdata = st_q.lo[st_q.idx];
            SEL_HI:  if (!st_q.idx_bad) csr_rdata = st_q.hi[st_q.idx];
            SEL_PID: csr_rdata = 32'(st_q.pid);
            default: ;
        endcase
    end

    assign hi_words = st_q.hi;
    assign lo_words = st_q.lo;
    assign tags     = st_q.tid;

    // R4: a high-word write tags the entry with the identifier held before the edge
    p_hi_tag_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && sel == SEL_HI && !st_q.idx_bad)
        |=> tags[$past(st_q.idx)] == $past(st_q.pid));

    // R1: writes through an invalid pointer leave storage untouched
    p_bad_ptr_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && st_q.idx_bad && (sel == SEL_LO || sel == SEL_HI))
        |=> ($stable(lo_words) && $stable(hi_words) && $stable(tags)));

    // R2: low flag nibble of the high word never reads back set
    p_hi_nibble_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_HI) |-> (csr_rdata[3:0] == 4'b0000));
endmodule

// File: rtl/swtlb_match.sv
module swtlb_match
    import swtlb_pkg::*;
#(
    parameter int unsigned PID_W = 8
) (
    input  logic [31:0]      hi_word,
    input  logic [PID_W-1:0] tag,
    input  logic [31:0]      vaddr,
    input  logic [PID_W-1:0] pid,
    output logic             hit
);
    logic [31:0] keep;
    logic        pid_ok;
    logic        unused_hi;

    assign keep      = ~page_off_mask(hi_word[HI_SIZE_LSB +: 3]) & MIN_PAGE_KEEP;
    assign pid_ok    = (tag == pid) || (tag == '0);
    assign hit       = hi_word[HI_VALID_BIT] && pid_ok && (((vaddr ^ hi_word) & keep) == 32'd0);
    assign unused_hi = ^hi_word[5:0];
endmodule

// File: rtl/swtlb_pick.sv
module swtlb_pick #(
    parameter int unsigned N = 64
) (
    input  logic [N-1:0]        hits,
    input  logic [N-1:0][31:0]  hi_words,
    input  logic [N-1:0][31:0]  lo_words,
    output logic                any_hit,
    output logic [31:0]         win_hi,
    output logic [31:0]         win_lo
);
    always_comb begin
        win_hi = '0;
        win_lo = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                win_hi = hi_words[i];
                win_lo = lo_words[i];
            end
        end
    end
    assign any_hit = |hits;
endmodule

// File: rtl/swtlb_unit.sv
module swtlb_unit
    import swtlb_pkg::*;
#(
    parameter int unsigned N     = 64,
    parameter int unsigned PID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        csr_sel,
    input  logic              csr_we,
    input  logic              csr_re,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata,
    input  logic [31:0]       lk_vaddr,
    input  logic [PID_W-1:0]  lk_pid,
    input  logic [1:0]        lk_kind,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_fault,
    output logic [31:0]       lk_paddr
);
    logic [N-1:0][31:0]      hi_words, lo_words;
    logic [N-1:0][PID_W-1:0] tags;
    logic [N-1:0]            hits;
    logic [31:0]             win_hi, win_lo, off_mask;
    acc_kind_e               kind;
    logic                    unused_bits;

    swtlb_regs #(.N(N), .PID_W(PID_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .csr_sel(csr_sel), .csr_we(csr_we),
        .csr_re(csr_re), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .hi_words(hi_words), .lo_words(lo_words), .tags(tags)
    );

    for (genvar g = 0; g < N; g++) begin : g_cmp
        swtlb_match #(.PID_W(PID_W)) u_cmp (
            .hi_word(hi_words[g]), .tag(tags[g]), .vaddr(lk_vaddr),
            .pid(lk_pid), .hit(hits[g])
        );
    end

    swtlb_pick #(.N(N)) u_pick (
        .hits(hits), .hi_words(hi_words), .lo_words(lo_words),
        .any_hit(lk_hit), .win_hi(win_hi), .win_lo(win_lo)
    );

    assign kind     = acc_kind_e'(lk_kind);
    assign off_mask = page_off_mask(win_hi[HI_SIZE_LSB +: 3]);
    assign lk_paddr = (win_lo & ~off_mask) | (lk_vaddr & off_mask);
    assign lk_miss  = !lk_hit;
    assign lk_fault = lk_hit && ((kind == ACC_WRITE && !win_lo[LO_WR_BIT]) ||
                                 (kind == ACC_FETCH && !win_lo[LO_EX_BIT]));
    assign unused_bits = ^{win_hi[31:10], win_hi[6:0], win_lo[7:0]};

    // R8: a fault needs a hit
    p_fault_needs_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> lk_hit);
    // R8: plain reads never fault
    p_read_no_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_kind == 2'd0) |-> !lk_fault);
    // R7: the smallest page keeps ten offset bits untranslated
    p_offset_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[9:0] == lk_vaddr[9:0]));
endmodule

// File: tb/swtlb_unit_test.sv
module swtlb_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  csr_sel = '0;
    logic        csr_we = 1'b0, csr_re = 1'b0;
    logic [31:0] csr_wdata = '0, csr_rdata;
    logic [31:0] lk_vaddr = '0, lk_paddr;
    logic [7:0]  lk_pid = '0;
    logic [1:0]  lk_kind = '0;
    logic        lk_hit, lk_miss, lk_fault;

    always #5 clk = ~clk;

    swtlb_unit uut (
        .clk(clk), .rst_n(rst_n), .csr_sel(csr_sel), .csr_we(csr_we),
        .csr_re(csr_re), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .lk_vaddr(lk_vaddr), .lk_pid(lk_pid), .lk_kind(lk_kind),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_paddr(lk_paddr)
    );

    typedef struct {
        string       req;
        bit          is_csr;
        logic [31:0] exp_data;
        bit          exp_hit;
        bit          exp_fault;
    } item_t;

    item_t q[$];
    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    // Monitor: compares one expected item per cycle, away from the active edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_tests++;
            if (it.is_csr) begin
                if (csr_rdata !== it.exp_data) begin
                    n_fail++;
                    $display("FAIL %s: rdata actual %h expected %h", it.req, csr_rdata, it.exp_data);
                end
            end else if (lk_hit !== it.exp_hit || lk_miss !== !it.exp_hit ||
                         (it.exp_hit && (lk_fault !== it.exp_fault || lk_paddr !== it.exp_data))) begin
                n_fail++;
                $display("FAIL %s: hit/miss/fault/pa actual %b/%b/%b/%h expected %b/%b/%b/%h",
                         it.req, lk_hit, lk_miss, lk_fault, lk_paddr,
                         it.exp_hit, !it.exp_hit, it.exp_fault, it.exp_data);
            end
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        csr_sel = sel; csr_wdata = d; csr_we = 1'b1;
        @(posedge clk); #1;
        csr_we = 1'b0;
    endtask

    task automatic chk_csr(input string req, input logic [1:0] sel, input logic [31:0] exp);
        item_t it;
        csr_sel = sel;
        it.req = req; it.is_csr = 1'b1; it.exp_data = exp; it.exp_hit = 1'b0; it.exp_fault = 1'b0;
        q.push_back(it);
        @(posedge clk); #1;
    endtask

    task automatic read_hi_strobe(input string req, input logic [31:0] exp);
        item_t it;
        csr_sel = 2'd2; csr_re = 1'b1;
        it.req = req; it.is_csr = 1'b1; it.exp_data = exp; it.exp_hit = 1'b0; it.exp_fault = 1'b0;
        q.push_back(it);
        @(posedge clk); #1;
        csr_re = 1'b0;
    endtask

    task automatic look(input string req, input logic [31:0] va, input logic [7:0] pid,
                        input logic [1:0] kind, input bit hit, input bit flt, input logic [31:0] pa);
        item_t it;
        lk_vaddr = va; lk_pid = pid; lk_kind = kind;
        it.req = req; it.is_csr = 1'b0; it.exp_data = pa; it.exp_hit = hit; it.exp_fault = flt;
        q.push_back(it);
        @(posedge clk); #1;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R5 reset state
        chk_csr("R5 pointer", 2'd0, 32'h0);
        chk_csr("R5 pid", 2'd3, 32'h0);
        chk_csr("R5 low word", 2'd1, 32'h0);
        look("R5 lookup miss", 32'h0000_0000, 8'd0, 2'd0, 1'b0, 1'b0, 32'h0);

        // Entry 5: 4 KiB page, pid 7, write-only permission, zone/attr bits set
        wr(2'd0, 32'd5);
        wr(2'd3, 32'd7);
        wr(2'd1, 32'h8765_41AF);
        wr(2'd2, 32'h4000_00FF);
        // R11 lookup in the cycle right after the write
        look("R11 R6 R7 hit 4K", 32'h4000_0ABC, 8'd7, 2'd0, 1'b1, 1'b0, 32'h8765_4ABC);
        chk_csr("R3 low readback", 2'd1, 32'h8765_41AF);
        chk_csr("R2 high readback", 2'd2, 32'h4000_00F0);
        look("R6 above page miss", 32'h4000_1000, 8'd7, 2'd0, 1'b0, 1'b0, 32'h0);
        look("R6 pid mismatch", 32'h4000_0ABC, 8'd3, 2'd0, 1'b0, 1'b0, 32'h0);
        look("R8 write allowed", 32'h4000_0ABC, 8'd7, 2'd1, 1'b1, 1'b0, 32'h8765_4ABC);
        look("R8 fetch fault", 32'h4000_0ABC, 8'd7, 2'd2, 1'b1, 1'b1, 32'h8765_4ABC);
        look("R8 kind3 as read", 32'h4000_0ABC, 8'd7, 2'd3, 1'b1, 1'b0, 32'h8765_4ABC);

        // R4 tag round trip
        wr(2'd3, 32'd9);
        read_hi_strobe("R4 hi strobe read", 32'h4000_00F0);
        chk_csr("R4 pid from tag", 2'd3, 32'd7);

        // R1 invalid pointer
        wr(2'd0, 32'd100);
        chk_csr("R1 pointer readback", 2'd0, 32'd100);
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd2, 32'hFFFF_FFFF);
        chk_csr("R1 bad low reads zero", 2'd1, 32'h0);
        wr(2'd0, 32'd36);
        chk_csr("R1 entry 36 untouched", 2'd2, 32'h0);
        wr(2'd0, 32'd5);
        chk_csr("R1 entry 5 kept", 2'd1, 32'h8765_41AF);

        // Entry 2: 16 MiB global, execute-only
        wr(2'd0, 32'd2);
        wr(2'd3, 32'd0);
        wr(2'd1, 32'h0100_0200);
        wr(2'd2, 32'h4000_03C0);
        look("R9 lowest wins", 32'h4000_0ABC, 8'd7, 2'd2, 1'b1, 1'b0, 32'h0100_0ABC);
        look("R8 write fault on winner", 32'h4000_0ABC, 8'd7, 2'd1, 1'b1, 1'b1, 32'h0100_0ABC);
        look("R6 global tag 16M", 32'h40FF_1234, 8'd55, 2'd0, 1'b1, 1'b0, 32'h01FF_1234);

        // Entry 10: 1 KiB global
        wr(2'd0, 32'd10);
        wr(2'd1, 32'h0000_0F00);
        wr(2'd2, 32'h8000_0440);
        look("R6 1K bit10 miss", 32'h8000_03FF, 8'd1, 2'd0, 1'b0, 1'b0, 32'h0);
        look("R7 1K hit", 32'h8000_04FF, 8'd1, 2'd0, 1'b1, 1'b0, 32'h0000_0CFF);

        // R10 removal
        wr(2'd0, 32'd2);
        wr(2'd3, 32'd0);
        wr(2'd2, 32'd0);
        wr(2'd1, 32'd0);
        look("R10 entry 2 removed", 32'h4000_0ABC, 8'd7, 2'd0, 1'b1, 1'b0, 32'h8765_4ABC);
        wr(2'd0, 32'd5);
        wr(2'd2, 32'd0);
        wr(2'd1, 32'd0);
        look("R10 entry 5 removed", 32'h4000_0ABC, 8'd7, 2'd0, 1'b0, 1'b0, 32'h0);

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule